// File: doc/BRIEF.md
# Dual-Bank Load/Store Address Generator

This block produces memory addresses for a signal-processing datapath whose registers are split into two banks. Each bank has four 16-bit address pointers and eight 16-bit data registers. In each clock cycle the block can accept one memory micro-operation per bank, so up to two run in parallel. An operation selects a pointer, an addressing mode and an access width. The access width is either a single 16-bit data register or an even/odd register pair that moves 32 bits. The block updates the selected pointer as the mode dictates. It presents the resulting memory address and a direction flag, together with the data-register masks the datapath needs. For loads the mask shows which registers receive memory data. For stores it shows which registers supply it.

A separate constant-write command can overwrite any pointer in either bank. The issuing logic, the data registers themselves and the memory are outside the block. Every registered result appears one clock after the operation is presented.

Top module: `dual_bank_agu`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the memory enables, write flags, addresses and both register masks of both banks read zero. All eight pointers start at 0.
- R2: An accepted operation drives `x_mem_en` high on the following cycle, with `x_mem_we` equal to its store bit. A cycle with no accepted operation drives `x_mem_en` and `x_mem_we` low, and `x_mem_addr` keeps its last value.
- R3: Mode code 1 (post-increment) and mode code 2 (post-decrement) access at the pointer's current value. The pointer then moves up or down by one step.
- R4: Mode code 3 (pre-increment) and mode code 4 (pre-decrement) move the pointer by one step first. The access uses the moved value, which is also what the pointer keeps.
- R5: The step is 1 for a 16-bit access and 2 for a paired access. Pointer arithmetic wraps modulo 2^16.
- R6: A 16-bit access may name any data register 0 to 7 and produces a one-hot mask with bit n set for register n. A load places the mask on `x_dreg_we` and a store places it on `x_dreg_re`. The unused mask reads zero.
- R7: A paired access is accepted only for data register 0, 2 or 4. Its mask sets bit n (low 16 bits of the 32-bit word) and bit n+1 (high 16 bits). A paired access naming register 1, 3, 5, 6 or 7 is dropped: there is no memory access, both masks stay zero and no pointer changes.
- R8: The two banks work in the same cycle without interference. Each uses only its own pointers, and any mix of load/store and 16-bit/paired access is allowed across the two.
- R9: A constant-write command writes `imm_value` into pointer `imm_areg` of bank A when `imm_bank` is 0, or of bank B when it is 1. The write takes effect at the next clock edge.
- R10: When a constant write and a modifying access target the same pointer in one cycle, the pointer takes the constant. The access itself still goes out at the address its mode would give.
- R11: Mode code 0 (plain), and the unused codes 5 to 7, access at the pointer's current value and leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Bank A operation present |
| a_store | input | 1 | Bank A: 1 store, 0 load |
| a_long | input | 1 | Bank A: 1 paired 32-bit access, 0 16-bit access |
| a_areg | input | 2 | Bank A pointer index |
| a_mode | input | 3 | Bank A addressing mode code |
| a_dreg | input | 3 | Bank A data register index |
| b_valid | input | 1 | Bank B operation present |
| b_store | input | 1 | Bank B: 1 store, 0 load |
| b_long | input | 1 | Bank B: 1 paired 32-bit access, 0 16-bit access |
| b_areg | input | 2 | Bank B pointer index |
| b_mode | input | 3 | Bank B addressing mode code |
| b_dreg | input | 3 | Bank B data register index |
| imm_valid | input | 1 | Constant-write command present |
| imm_bank | input | 1 | Constant-write target bank (0 A, 1 B) |
| imm_areg | input | 2 | Constant-write target pointer |
| imm_value | input | 16 | Constant to write |
| a_mem_en | output | 1 | Bank A memory access this cycle |
| a_mem_we | output | 1 | Bank A memory write |
| a_mem_addr | output | 16 | Bank A effective address |
| a_dreg_we | output | 8 | Bank A data registers loaded from memory |
| a_dreg_re | output | 8 | Bank A data registers stored to memory |
| b_mem_en | output | 1 | Bank B memory access this cycle |
| b_mem_we | output | 1 | Bank B memory write |
| b_mem_addr | output | 16 | Bank B effective address |
| b_dreg_we | output | 8 | Bank B data registers loaded from memory |
| b_dreg_re | output | 8 | Bank B data registers stored to memory |

## Verification
The properties assume that every input is a known value at each rising edge. They also assume that operation fields are only meaningful when the matching valid bit is high, and that reset is held for at least one edge before any operation. The stimulus holds every valid bit low during reset and changes inputs only on falling edges. Beyond the directed sequences, it sweeps all mode codes, including the unused ones, and all data-register indices. This deliberately includes paired accesses on odd or too-high registers, so that the rejection path is exercised as well.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_PLAIN    = 3'd0,
        MD_POST_INC = 3'd1,
        MD_POST_DEC = 3'd2,
        MD_PRE_INC  = 3'd3,
        MD_PRE_DEC  = 3'd4
    } addr_mode_e;

endpackage

// File: rtl/agu_step.sv
// Effective-address and pointer-update arithmetic for one operation.
module agu_step
    import agu_pkg::*;
#(
    parameter int AW         = 16,
    parameter int SHORT_STEP = 1,
    parameter int LONG_STEP  = 2
) (
    input  logic [AW-1:0]     cur,
    input  logic [MODE_W-1:0] mode,
    input  logic              is_long,
    output logic [AW-1:0]     eff,
    output logic [AW-1:0]     nxt,
    output logic              modifies
);

    logic [AW-1:0] step;

    always_comb begin
        step = is_long ? AW'(LONG_STEP) : AW'(SHORT_STEP);
        eff      = cur;
        nxt      = cur;
        modifies = 1'b0;
        case (addr_mode_e'(mode))
            MD_POST_INC: begin
                nxt      = cur + step;
                modifies = 1'b1;
            end
            MD_POST_DEC: begin
                nxt      = cur - step;
                modifies = 1'b1;
            end
            MD_PRE_INC: begin
                eff      = cur + step;
                nxt      = cur + step;
                modifies = 1'b1;
            end
            MD_PRE_DEC: begin
                eff      = cur - step;
                nxt      = cur - step;
                modifies = 1'b1;
            end
            default: begin
                eff      = cur;
                nxt      = cur;
                modifies = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/agu_bank.sv
// One bank: pointer file, operation acceptance and registered outputs.
module agu_bank
    import agu_pkg::*;
#(
    parameter  int AW         = 16,
    parameter  int NAREG      = 4,
    parameter  int NDREG      = 8,
    parameter  int SHORT_STEP = 1,
    parameter  int LONG_STEP  = 2,
    localparam int ARW        = $clog2(NAREG),
    localparam int DRW        = $clog2(NDREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_store,
    input  logic              op_long,
    input  logic [ARW-1:0]    op_areg,
    input  logic [MODE_W-1:0] op_mode,
    input  logic [DRW-1:0]    op_dreg,
    input  logic              imm_hit,
    input  logic [ARW-1:0]    imm_areg,
    input  logic [AW-1:0]     imm_value,
    output logic              mem_en,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [NDREG-1:0]  dreg_we,
    output logic [NDREG-1:0]  dreg_re
);

    logic [AW-1:0]    regs_q [NAREG];
    logic [AW-1:0]    regs_d [NAREG];
    logic [AW-1:0]    cur;
    logic [AW-1:0]    eff;
    logic [AW-1:0]    nxt;
    logic             modifies;
    logic             size_ok;
    logic             issue;
    logic [NDREG-1:0] mask;

    assign cur = regs_q[op_areg];

    agu_step #(
        .AW         (AW),
        .SHORT_STEP (SHORT_STEP),
        .LONG_STEP  (LONG_STEP)
    ) u_step (
        .cur      (cur),
        .mode     (op_mode),
        .is_long  (op_long),
        .eff      (eff),
        .nxt      (nxt),
        .modifies (modifies)
    );

    // Paired accesses need an even low register with its partner below the top pair.
    always_comb begin
        size_ok = !op_long || (!op_dreg[0] && (int'(op_dreg) < NDREG - 2));
        issue   = op_valid && size_ok;
        if (op_long) mask = NDREG'(3) << op_dreg;
        else         mask = NDREG'(1) << op_dreg;
    end

    // Pointer next state; the constant write is applied last so it wins.
    always_comb begin
        for (int i = 0; i < NAREG; i++) regs_d[i] = regs_q[i];
        if (issue && modifies) regs_d[op_areg] = nxt;
        if (imm_hit)           regs_d[imm_areg] = imm_value;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NAREG; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NAREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_en   <= 1'b0;
            mem_we   <= 1'b0;
            mem_addr <= '0;
            dreg_we  <= '0;
            dreg_re  <= '0;
        end else begin
            mem_en  <= issue;
            mem_we  <= issue && op_store;
            dreg_we <= (issue && !op_store) ? mask : '0;
            dreg_re <= (issue &&  op_store) ? mask : '0;
            if (issue) mem_addr <= eff;
        end
    end

endmodule

// File: rtl/dual_bank_agu.sv
module dual_bank_agu
    import agu_pkg::*;
#(
    parameter  int AW         = 16,
    parameter  int NAREG      = 4,
    parameter  int NDREG      = 8,
    parameter  int SHORT_STEP = 1,
    parameter  int LONG_STEP  = 2,
    localparam int ARW        = $clog2(NAREG),
    localparam int DRW        = $clog2(NDREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_valid,
    input  logic              a_store,
    input  logic              a_long,
    input  logic [ARW-1:0]    a_areg,
    input  logic [MODE_W-1:0] a_mode,
    input  logic [DRW-1:0]    a_dreg,
    input  logic              b_valid,
    input  logic              b_store,
    input  logic              b_long,
    input  logic [ARW-1:0]    b_areg,
    input  logic [MODE_W-1:0] b_mode,
    input  logic [DRW-1:0]    b_dreg,
    input  logic              imm_valid,
    input  logic              imm_bank,
    input  logic [ARW-1:0]    imm_areg,
    input  logic [AW-1:0]     imm_value,
    output logic              a_mem_en,
    output logic              a_mem_we,
    output logic [AW-1:0]     a_mem_addr,
    output logic [NDREG-1:0]  a_dreg_we,
    output logic [NDREG-1:0]  a_dreg_re,
    output logic              b_mem_en,
    output logic              b_mem_we,
    output logic [AW-1:0]     b_mem_addr,
    output logic [NDREG-1:0]  b_dreg_we,
    output logic [NDREG-1:0]  b_dreg_re
);

    localparam int NBANK = 2;

    logic [NBANK-1:0]  v_in, st_in, lg_in, en_o, we_o;
    logic [ARW-1:0]    ar_in [NBANK];
    logic [MODE_W-1:0] md_in [NBANK];
    logic [DRW-1:0]    dr_in [NBANK];
    logic [AW-1:0]     addr_o [NBANK];
    logic [NDREG-1:0]  wm_o [NBANK];
    logic [NDREG-1:0]  rm_o [NBANK];

    assign v_in  = {b_valid, a_valid};
    assign st_in = {b_store, a_store};
    assign lg_in = {b_long,  a_long};
    assign ar_in[0] = a_areg;
    assign ar_in[1] = b_areg;
    assign md_in[0] = a_mode;
    assign md_in[1] = b_mode;
    assign dr_in[0] = a_dreg;
    assign dr_in[1] = b_dreg;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        agu_bank #(
            .AW         (AW),
            .NAREG      (NAREG),
            .NDREG      (NDREG),
            .SHORT_STEP (SHORT_STEP),
            .LONG_STEP  (LONG_STEP)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .op_valid  (v_in[g]),
            .op_store  (st_in[g]),
            .op_long   (lg_in[g]),
            .op_areg   (ar_in[g]),
            .op_mode   (md_in[g]),
            .op_dreg   (dr_in[g]),
            .imm_hit   (imm_valid && (int'(imm_bank) == g)),
            .imm_areg  (imm_areg),
            .imm_value (imm_value),
            .mem_en    (en_o[g]),
            .mem_we    (we_o[g]),
            .mem_addr  (addr_o[g]),
            .dreg_we   (wm_o[g]),
            .dreg_re   (rm_o[g])
        );
    end

    assign a_mem_en   = en_o[0];
    assign a_mem_we   = we_o[0];
    assign a_mem_addr = addr_o[0];
    assign a_dreg_we  = wm_o[0];
    assign a_dreg_re  = rm_o[0];
    assign b_mem_en   = en_o[1];
    assign b_mem_we   = we_o[1];
    assign b_mem_addr = addr_o[1];
    assign b_dreg_we  = wm_o[1];
    assign b_dreg_re  = rm_o[1];

endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
    parameter  int NDREG = 8,
    localparam int DRW   = $clog2(NDREG)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a_valid,
    input logic             a_store,
    input logic             a_long,
    input logic [DRW-1:0]   a_dreg,
    input logic             b_valid,
    input logic             b_store,
    input logic             b_long,
    input logic [DRW-1:0]   b_dreg,
    input logic             a_mem_en,
    input logic             a_mem_we,
    input logic [NDREG-1:0] a_dreg_we,
    input logic [NDREG-1:0] a_dreg_re,
    input logic             b_mem_en,
    input logic             b_mem_we,
    input logic [NDREG-1:0] b_dreg_we,
    input logic [NDREG-1:0] b_dreg_re
);

    localparam logic [NDREG-1:0] EVEN_BITS = {(NDREG/2){2'b01}};
    localparam logic [NDREG-1:0] ODD_BITS  = EVEN_BITS << 1;

    logic [NDREG-1:0] a_mask, b_mask;
    assign a_mask = a_dreg_we | a_dreg_re;
    assign b_mask = b_dreg_we | b_dreg_re;

    // R2 / R8: each bank accesses memory only after its own request
    p_idle_quiet_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !a_valid |=> !a_mem_en);
    p_idle_quiet_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !b_valid |=> !b_mem_en);

    // R2: a 16-bit store becomes a memory write
    p_store_write_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid && a_store && !a_long |=> a_mem_en && a_mem_we);
    p_store_write_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid && b_store && !b_long |=> b_mem_en && b_mem_we);

    // R6: single register per 16-bit access
    p_short_onehot_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid && !a_long |=> $countones(a_mask) == 1);
    p_short_onehot_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid && !b_long |=> $countones(b_mask) == 1);

    // R6: mask direction follows the write flag
    p_mask_dir_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        a_mem_en |-> (a_mem_we ? (a_dreg_we == '0) : (a_dreg_re == '0)));
    p_mask_dir_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        b_mem_en |-> (b_mem_we ? (b_dreg_we == '0) : (b_dreg_re == '0)));

    // R7: a legal paired access covers one aligned even/odd pair
    p_long_pair_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid && a_long && !a_dreg[0] && (int'(a_dreg) < NDREG - 2) |=>
        a_mem_en && ($countones(a_mask) == 2) &&
        (((a_mask & EVEN_BITS) << 1) == (a_mask & ODD_BITS)));
    p_long_pair_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid && b_long && !b_dreg[0] && (int'(b_dreg) < NDREG - 2) |=>
        b_mem_en && ($countones(b_mask) == 2) &&
        (((b_mask & EVEN_BITS) << 1) == (b_mask & ODD_BITS)));

    // R7: a paired access on an odd register is dropped
    p_long_reject_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid && a_long && a_dreg[0] |=> !a_mem_en && (a_mask == '0));
    p_long_reject_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid && b_long && b_dreg[0] |=> !b_mem_en && (b_mask == '0));

endmodule

bind dual_bank_agu agu_checker #(.NDREG(NDREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_valid   (a_valid),
    .a_store   (a_store),
    .a_long    (a_long),
    .a_dreg    (a_dreg),
    .b_valid   (b_valid),
    .b_store   (b_store),
    .b_long    (b_long),
    .b_dreg    (b_dreg),
    .a_mem_en  (a_mem_en),
    .a_mem_we  (a_mem_we),
    .a_dreg_we (a_dreg_we),
    .a_dreg_re (a_dreg_re),
    .b_mem_en  (b_mem_en),
    .b_mem_we  (b_mem_we),
    .b_dreg_we (b_dreg_we),
    .b_dreg_re (b_dreg_re)
);

// File: tb/dual_bank_agu_test.sv
module dual_bank_agu_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        a_valid, a_store, a_long, b_valid, b_store, b_long;
    logic [1:0]  a_areg, b_areg, imm_areg;
    logic [2:0]  a_mode, b_mode, a_dreg, b_dreg;
    logic        imm_valid, imm_bank;
    logic [15:0] imm_value;
    logic        a_mem_en, a_mem_we, b_mem_en, b_mem_we;
    logic [15:0] a_mem_addr, b_mem_addr;
    logic [7:0]  a_dreg_we, a_dreg_re, b_dreg_we, b_dreg_re;

    dual_bank_agu uut (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_store(a_store), .a_long(a_long),
        .a_areg(a_areg), .a_mode(a_mode), .a_dreg(a_dreg),
        .b_valid(b_valid), .b_store(b_store), .b_long(b_long),
        .b_areg(b_areg), .b_mode(b_mode), .b_dreg(b_dreg),
        .imm_valid(imm_valid), .imm_bank(imm_bank),
        .imm_areg(imm_areg), .imm_value(imm_value),
        .a_mem_en(a_mem_en), .a_mem_we(a_mem_we), .a_mem_addr(a_mem_addr),
        .a_dreg_we(a_dreg_we), .a_dreg_re(a_dreg_re),
        .b_mem_en(b_mem_en), .b_mem_we(b_mem_we), .b_mem_addr(b_mem_addr),
        .b_dreg_we(b_dreg_we), .b_dreg_re(b_dreg_re)
    );

    // stimulus per bank
    bit s_v[2], s_st[2], s_lg[2];
    int s_ar[2], s_md[2], s_dr[2];
    bit i_v;
    int i_bank, i_ar, i_val;

    assign a_valid = s_v[0];  assign b_valid = s_v[1];
    assign a_store = s_st[0]; assign b_store = s_st[1];
    assign a_long  = s_lg[0]; assign b_long  = s_lg[1];
    assign a_areg  = s_ar[0][1:0]; assign b_areg = s_ar[1][1:0];
    assign a_mode  = s_md[0][2:0]; assign b_mode = s_md[1][2:0];
    assign a_dreg  = s_dr[0][2:0]; assign b_dreg = s_dr[1][2:0];
    assign imm_valid = i_v;
    assign imm_bank  = i_bank[0];
    assign imm_areg  = i_ar[1:0];
    assign imm_value = i_val[15:0];

    // behavioural reference
    int    mreg[2][4];
    bit    e_en[2], e_we[2];
    int    e_addr[2], e_wm[2], e_rm[2];
    string t_addr[2], t_mask[2];
    string phase = "reset";
    int    vectors = 0, miscompares = 0;
    bit    done = 0;

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s (%s): actual %0h expected %0h", tag, phase, act, exp);
        end
    endtask

    function automatic int act_en(int b);   return b == 0 ? int'(a_mem_en) : int'(b_mem_en); endfunction
    function automatic int act_we(int b);   return b == 0 ? int'(a_mem_we) : int'(b_mem_we); endfunction
    function automatic int act_addr(int b); return b == 0 ? int'(a_mem_addr) : int'(b_mem_addr); endfunction
    function automatic int act_wm(int b);   return b == 0 ? int'(a_dreg_we) : int'(b_dreg_we); endfunction
    function automatic int act_rm(int b);   return b == 0 ? int'(a_dreg_re) : int'(b_dreg_re); endfunction

    task automatic clear_ops();
        for (int b = 0; b < 2; b++) begin
            s_v[b] = 0; s_st[b] = 0; s_lg[b] = 0; s_ar[b] = 0; s_md[b] = 0; s_dr[b] = 0;
        end
        i_v = 0; i_bank = 0; i_ar = 0; i_val = 0;
    endtask

    task automatic set_op(int b, bit st, bit lg, int ar, int md, int dr);
        s_v[b] = 1; s_st[b] = st; s_lg[b] = lg; s_ar[b] = ar; s_md[b] = md; s_dr[b] = dr;
    endtask

    task automatic set_imm(int bank, int ar, int val);
        i_v = 1; i_bank = bank; i_ar = ar; i_val = val;
    endtask

    function automatic string mode_tag(int md);
        if (md == 1 || md == 2) return "R3";
        if (md == 3 || md == 4) return "R4";
        return "R11";
    endfunction

    // called at a falling edge with stimulus set; returns at the next falling edge
    task automatic cycle();
        for (int b = 0; b < 2; b++) begin
            int  cur  = mreg[b][s_ar[b]];
            int  step = s_lg[b] ? 2 : 1;
            bit  ok   = !s_lg[b] || ((s_dr[b] % 2 == 0) && s_dr[b] < 6);
            bit  iss  = s_v[b] && ok;
            int  eff  = cur;
            int  nxt  = cur;
            int  mask = s_lg[b] ? (3 << s_dr[b]) : (1 << s_dr[b]);
            case (s_md[b])
                1: nxt = cur + step;
                2: nxt = cur - step;
                3: begin eff = cur + step; nxt = eff; end
                4: begin eff = cur - step; nxt = eff; end
                default: ;
            endcase
            eff &= 16'hFFFF; nxt &= 16'hFFFF;
            e_en[b] = iss;
            e_we[b] = iss && s_st[b];
            if (iss) e_addr[b] = eff;
            e_wm[b] = (iss && !s_st[b]) ? mask : 0;
            e_rm[b] = (iss &&  s_st[b]) ? mask : 0;
            if (iss) mreg[b][s_ar[b]] = nxt;
            t_addr[b] = !s_v[b] ? "R2" : (!ok ? "R7" : mode_tag(s_md[b]));
            t_mask[b] = s_lg[b] ? "R7" : "R6";
        end
        if (i_v) mreg[i_bank][i_ar] = i_val & 16'hFFFF;
        @(posedge clk);
        #1;
        for (int b = 0; b < 2; b++) begin
            chk($sformatf("R2 bank%0d mem_en", b), act_en(b), int'(e_en[b]));
            chk($sformatf("R2 bank%0d mem_we", b), act_we(b), int'(e_we[b]));
            chk($sformatf("%s bank%0d addr", t_addr[b], b), act_addr(b), e_addr[b]);
            chk($sformatf("%s bank%0d load mask", t_mask[b], b), act_wm(b), e_wm[b]);
            chk($sformatf("%s bank%0d store mask", t_mask[b], b), act_rm(b), e_rm[b]);
        end
        @(negedge clk);
        clear_ops();
    endtask

    initial begin
        clear_ops();
        rst_n = 0;
        for (int b = 0; b < 2; b++) begin
            e_en[b] = 0; e_we[b] = 0; e_addr[b] = 0; e_wm[b] = 0; e_rm[b] = 0;
            for (int r = 0; r < 4; r++) mreg[b][r] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        phase = "R1";
        for (int b = 0; b < 2; b++) begin
            chk("R1 mem_en in reset", act_en(b), 0);
            chk("R1 mem_we in reset", act_we(b), 0);
            chk("R1 addr in reset", act_addr(b), 0);
            chk("R1 masks in reset", act_wm(b) | act_rm(b), 0);
        end
        rst_n = 1;
        cycle();                                  // R1: idle first cycle stays zero
        set_op(0, 0, 0, 3, 0, 1); set_op(1, 1, 0, 2, 0, 6); cycle();  // R1 pointers at 0

        phase = "R9";
        set_imm(0, 2, 16'h1234); cycle();
        set_imm(1, 1, 16'hBEEF); cycle();
        set_op(0, 0, 0, 2, 0, 0); set_op(1, 0, 0, 1, 0, 7); cycle();

        phase = "R3";
        set_op(0, 0, 0, 2, 1, 3); cycle();
        set_op(0, 1, 0, 2, 1, 3); cycle();
        set_op(1, 0, 1, 1, 2, 2); cycle();
        set_op(1, 0, 0, 1, 0, 2); set_op(0, 0, 0, 2, 0, 5); cycle();

        phase = "R4";
        set_op(0, 0, 1, 2, 3, 4); set_op(1, 1, 0, 1, 4, 0); cycle();
        set_op(0, 0, 0, 2, 0, 1); set_op(1, 0, 0, 1, 0, 1); cycle();

        phase = "R5";
        set_imm(0, 0, 16'hFFFF); cycle();
        set_op(0, 0, 0, 0, 1, 0); cycle();
        set_op(0, 0, 0, 0, 0, 0); cycle();
        set_imm(1, 0, 16'h0001); cycle();
        set_op(1, 1, 1, 0, 4, 2); cycle();
        set_op(1, 0, 0, 0, 0, 0); cycle();

        phase = "R7";
        set_op(0, 0, 1, 2, 3, 3); set_op(1, 1, 1, 1, 1, 6); cycle();
        set_op(0, 0, 0, 2, 0, 0); set_op(1, 0, 0, 1, 0, 0); cycle();
        set_op(0, 1, 1, 2, 0, 4); set_op(1, 0, 1, 1, 0, 0); cycle();

        phase = "R10";
        set_imm(0, 1, 16'h0100); set_op(0, 0, 0, 1, 1, 2); cycle();
        set_op(0, 0, 0, 1, 0, 2); cycle();
        set_imm(1, 3, 16'h0F00); set_op(1, 0, 1, 3, 3, 0); cycle();
        set_op(1, 0, 0, 3, 0, 0); cycle();

        phase = "R8";
        for (int k = 0; k < 6; k++) begin
            set_op(0, k[0], 0, 2, 1, k);
            set_op(1, !k[0], 1, 1, 4, 2 * (k % 3));
            cycle();
        end

        phase = "R6";
        for (int d = 0; d < 8; d++) begin
            set_op(0, 0, 0, 3, 0, d); set_op(1, 1, 0, 3, 0, 7 - d); cycle();
        end

        phase = "R11";
        for (int m = 5; m < 8; m++) begin
            set_op(0, 0, 0, 2, m, 0); set_op(1, 0, 0, 1, m, 0); cycle();
        end
        set_op(0, 0, 0, 2, 0, 0); set_op(1, 0, 0, 1, 0, 0); cycle();

        phase = "random";
        for (int n = 0; n < 3000; n++) begin
            for (int b = 0; b < 2; b++) begin
                s_v[b]  = ($urandom % 4) != 0;
                s_st[b] = $urandom % 2;
                s_lg[b] = $urandom % 2;
                s_ar[b] = $urandom % 4;
                s_md[b] = $urandom % 8;
                s_dr[b] = $urandom % 8;
            end
            if ($urandom % 5 == 0)
                set_imm($urandom % 2, $urandom % 4,
                        ($urandom % 3 == 0) ? 16'hFFFE + ($urandom % 2) : ($urandom % 65536));
            cycle();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog (%s): actual hung expected finished", phase);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule